// File: doc/BRIEF.md
# I2S Dual-Mono Channel Splitter

This block takes one stereo serial audio stream (bit clock, word select, serial data) and produces two serial data lines that share one realigned word select. The first data line carries the left sample in both slots of every frame. The second carries the right sample in both slots. Each of two stereo converters can then be driven as a mono converter, with its two internal channels summed.

The serial data runs through a single delay line clocked by the bit clock. The line has taps at one, two and three slot lengths. For each output, a selector picks one tap according to the current output slot, so samples are copied by position in time and never stored as parallel words. A static mode input complements the right-slot bits of both outputs, which gives an inverted copy for balanced use. Inputs are sampled on the rising bit-clock edge. Outputs are registered on the falling edge, so downstream converters see settled data when they sample on the rising edge.

Top module: `i2s_mono_split`

## Requirements
- R1: From reset until `valid_o` asserts, `ws_o`, `sd_ll_o`, `sd_rr_o` and `valid_o` are all low.
- R2: Counting rising edges from 0 after reset release, `valid_o` goes high at the falling edge that follows rising edge 96. It then stays high until reset.
- R3: Once valid, `ws_o` after rising edge n equals the `ws_i` sampled at edge n-64.
- R4: Once valid, `sd_ll_o` after edge n equals the `sd_i` from edge n-64 when the `ws_i` sampled at edge n-65 was low (output left slot). When that sample was high (output right slot), it equals the `sd_i` from edge n-96.
- R5: Once valid, `sd_rr_o` after edge n equals the `sd_i` from edge n-32 in the output left slot and the `sd_i` from edge n-64 in the output right slot, where the slot is defined as in R4.
- R6: With `inv_en_i` high, every right-slot bit of both outputs is the complement of the value given in R4/R5. Left-slot bits are unchanged.
- R7: The frame is 64 bit clocks long. Word select is low for the left slot and high for the right slot, and it changes one bit before each slot's MSB. Each slot holds a 32-bit word sent MSB first. With this format, every output frame carries the left word in both slots of `sd_ll_o` and the right word in both slots of `sd_rr_o`, bit-exact.
- R8: Asserting `rst_ni` low mid-stream clears all outputs at once, without waiting for a clock. After release, the fill sequence of R2 starts again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock; inputs sampled on rising edge, outputs updated on falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ws_i | input | 1 | Input word select (low = left slot) |
| sd_i | input | 1 | Input serial data |
| inv_en_i | input | 1 | Static mode: complement right-slot bits of both outputs |
| ws_o | output | 1 | Realigned word select shared by both outputs |
| sd_ll_o | output | 1 | Serial data carrying the left sample in both slots |
| sd_rr_o | output | 1 | Serial data carrying the right sample in both slots |
| valid_o | output | 1 | High once the delay line holds enough history |

## Verification
On every cycle, the assertions check four things: outputs stay silent while the line is filling, the fill count never passes its limit, valid never drops outside reset, and the slot used by the tap selectors always trails the output word select by exactly one bit. Which tap each output uses in each slot, the effect of the inversion mode, and the exact moment valid rises can only be shown by the bench. It compares each output bit against the input history at the required distance. Bit-exact duplication of whole words, and the immediate clearing on a mid-stream reset, are also shown only by the bench's scenarios.

// File: rtl/split_pkg.sv
package split_pkg;

    // Tap indices along the bit-clock delay line (multiples of one slot)
    localparam int TAP_NEAR = 0;   // one slot back
    localparam int TAP_MID  = 1;   // two slots back
    localparam int TAP_FAR  = 2;   // three slots back
    localparam int NUM_TAPS = 3;

    // Number of mono lanes produced
    localparam int NUM_LANES = 2;

    // Tap used by a lane in the output left slot
    function automatic int lane_left_tap(input int lane);
        return (lane == 0) ? TAP_MID : TAP_NEAR;
    endfunction

    // Tap used by a lane in the output right slot
    function automatic int lane_right_tap(input int lane);
        return (lane == 0) ? TAP_FAR : TAP_MID;
    endfunction

endpackage

// File: rtl/split_delay.sv
module split_delay
    import split_pkg::*;
#(
    parameter int SLOT_BITS = 32
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                sd_i,
    input  logic                ws_i,
    output logic [NUM_TAPS-1:0] taps_o,
    output logic                ws_al_o,
    output logic                slot_o,
    output logic                valid_o
);

    localparam int DATA_LEN = NUM_TAPS * SLOT_BITS + 1;
    localparam int WS_LEN   = 2 * SLOT_BITS + 2;
    localparam int FILL     = DATA_LEN;
    localparam int CNT_W    = $clog2(FILL + 1);

    typedef struct packed {
        logic [DATA_LEN-1:0] sd;
        logic [WS_LEN-1:0]   ws;
        logic [CNT_W-1:0]    cnt;
        logic                valid;
    } dly_t;

    dly_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sd    = {st_q.sd[DATA_LEN-2:0], sd_i};
        st_d.ws    = {st_q.ws[WS_LEN-2:0], ws_i};
        if (st_q.cnt != CNT_W'(FILL)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        st_d.valid = (st_d.cnt == CNT_W'(FILL));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        assign taps_o[k] = st_q.sd[(k + 1) * SLOT_BITS];
    end

    assign ws_al_o = st_q.ws[2 * SLOT_BITS];
    assign slot_o  = st_q.ws[2 * SLOT_BITS + 1];
    assign valid_o = st_q.valid;

    AST_FILL_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= CNT_W'(FILL)); // R2

    AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.valid |=> st_q.valid); // R2

endmodule

// File: rtl/split_lane.sv
module split_lane
    import split_pkg::*;
#(
    parameter int LEFT_TAP  = TAP_MID,
    parameter int RIGHT_TAP = TAP_FAR
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_TAPS-1:0] taps_i,
    input  logic                slot_i,
    input  logic                valid_i,
    input  logic                inv_i,
    output logic                sd_o
);

    typedef struct packed {
        logic sd;
    } lane_t;

    lane_t ln_d, ln_q;

    always_comb begin
        ln_d.sd = 1'b0;
        if (valid_i) begin
            if (slot_i) begin
                ln_d.sd = taps_i[RIGHT_TAP] ^ inv_i;
            end else begin
                ln_d.sd = taps_i[LEFT_TAP];
            end
        end
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign sd_o = ln_q.sd;

    AST_LANE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |-> !sd_o); // R1

endmodule

// File: rtl/split_frame.sv
module split_frame (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ws_al_i,
    input  logic valid_i,
    output logic ws_o,
    output logic valid_o
);

    typedef struct packed {
        logic ws;
        logic valid;
    } frm_t;

    frm_t fr_d, fr_q;

    always_comb begin
        fr_d.valid = valid_i;
        fr_d.ws    = valid_i & ws_al_i;
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign ws_o    = fr_q.ws;
    assign valid_o = fr_q.valid;

    AST_WS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> !ws_o); // R1

endmodule

// File: rtl/i2s_mono_split.sv
module i2s_mono_split
    import split_pkg::*;
#(
    parameter int SLOT_BITS = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ws_i,
    input  logic sd_i,
    input  logic inv_en_i,
    output logic ws_o,
    output logic sd_ll_o,
    output logic sd_rr_o,
    output logic valid_o
);

    logic [NUM_TAPS-1:0]  taps;
    logic                 ws_al;
    logic                 slot;
    logic                 core_valid;
    logic [NUM_LANES-1:0] lane_sd;

    split_delay #(.SLOT_BITS(SLOT_BITS)) u_delay (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sd_i    (sd_i),
        .ws_i    (ws_i),
        .taps_o  (taps),
        .ws_al_o (ws_al),
        .slot_o  (slot),
        .valid_o (core_valid)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        split_lane #(
            .LEFT_TAP  (lane_left_tap(g)),
            .RIGHT_TAP (lane_right_tap(g))
        ) u_lane (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .taps_i  (taps),
            .slot_i  (slot),
            .valid_i (core_valid),
            .inv_i   (inv_en_i),
            .sd_o    (lane_sd[g])
        );
    end

    split_frame u_frame (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ws_al_i (ws_al),
        .valid_i (core_valid),
        .ws_o    (ws_o),
        .valid_o (valid_o)
    );

    assign sd_ll_o = lane_sd[0];
    assign sd_rr_o = lane_sd[1];

    // Selector slot trails the shared output word select by one bit
    AST_SLOT_TRACKS_WS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && $past(valid_o)) |-> (slot == $past(ws_o))); // R3

    AST_OUT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> (!sd_ll_o && !sd_rr_o)); // R1

endmodule

// File: tb/sim_i2s_mono_split.sv
module sim_i2s_mono_split;

    localparam int CLK_PERIOD = 10;
    localparam int HIST       = 4096;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic ws_i = 1'b0;
    logic sd_i = 1'b0;
    logic inv_en_i = 1'b0;
    logic ws_o, sd_ll_o, sd_rr_o, valid_o;

    int total = 0;
    int bad = 0;
    int n = 0;
    bit done = 1'b0;

    logic s_h [HIST];
    logic w_h [HIST];
    logic ol_h [HIST];
    logic or_h [HIST];

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2s_mono_split u0 (
        .clk_i    (clk),
        .rst_ni   (rst_ni),
        .ws_i     (ws_i),
        .sd_i     (sd_i),
        .inv_en_i (inv_en_i),
        .ws_o     (ws_o),
        .sd_ll_o  (sd_ll_o),
        .sd_rr_o  (sd_rr_o),
        .valid_o  (valid_o)
    );

    task automatic check_bit(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b cycle=%0d t=%0t", req, act, exp, n, $time);
        end
    endtask

    task automatic check_word(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check_bit(req, valid_o, 1'b0);
        check_bit(req, ws_o, 1'b0);
        check_bit(req, sd_ll_o, 1'b0);
        check_bit(req, sd_rr_o, 1'b0);
    endtask

    // Expected outputs after rising edge n, computed from R1..R6
    task automatic expect_cycle();
        logic sel, exp_l, exp_r;
        if (n < 96) begin
            check_idle("R1");
            check_bit("R2", valid_o, 1'b0);
        end else begin
            check_bit("R2", valid_o, 1'b1);
            check_bit("R3", ws_o, w_h[n - 64]);
            sel   = w_h[n - 65];
            exp_l = sel ? (s_h[n - 96] ^ inv_en_i) : s_h[n - 64];
            exp_r = sel ? (s_h[n - 64] ^ inv_en_i) : s_h[n - 32];
            check_bit((sel && inv_en_i) ? "R6" : "R4", sd_ll_o, exp_l);
            check_bit((sel && inv_en_i) ? "R6" : "R5", sd_rr_o, exp_r);
        end
    endtask

    task automatic tick(input logic sd, input logic ws);
        sd_i = sd;
        ws_i = ws;
        s_h[n] = sd;
        w_h[n] = ws;
        @(posedge clk);
        @(negedge clk);
        #1;
        ol_h[n] = sd_ll_o;
        or_h[n] = sd_rr_o;
        expect_cycle();
        n++;
    endtask

    // Frame per R7: left word at phases 0..31, right at 32..63, ws one bit early
    task automatic run_frames(input int frames, input bit rnd,
                              input logic [31:0] a, input logic [31:0] b);
        for (int f = 0; f < frames; f++) begin
            logic [31:0] lw, rw;
            lw = rnd ? 32'($urandom) : a;
            rw = rnd ? 32'($urandom) : b;
            for (int p = 0; p < 64; p++) begin
                tick((p < 32) ? lw[31 - p] : rw[63 - p], (p >= 31) && (p < 63));
            end
        end
    endtask

    task automatic do_reset(input logic inv);
        @(negedge clk);
        #1;
        rst_ni = 1'b0;
        sd_i = 1'b0;
        ws_i = 1'b0;
        inv_en_i = inv;
        repeat (2) @(negedge clk);
        #1;
        rst_ni = 1'b1;
        n = 0;
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        check_idle("R1");
    endtask

    task automatic t_random_plain();
        do_reset(1'b0);
        run_frames(6, 1'b1, '0, '0);
    endtask

    task automatic t_random_inverted();
        do_reset(1'b1);
        run_frames(6, 1'b1, '0, '0);
    endtask

    task automatic t_bit_exact(input logic inv, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] ll_l, ll_r, rr_l, rr_r;
        do_reset(inv);
        run_frames(4, 1'b0, a, b);
        for (int i = 0; i < 32; i++) begin
            ll_l[31 - i] = ol_h[128 + i];
            ll_r[31 - i] = ol_h[160 + i];
            rr_l[31 - i] = or_h[128 + i];
            rr_r[31 - i] = or_h[160 + i];
        end
        check_word("R7", ll_l, a);
        check_word(inv ? "R6" : "R7", ll_r, inv ? ~a : a);
        check_word("R7", rr_l, b);
        check_word(inv ? "R6" : "R7", rr_r, inv ? ~b : b);
    endtask

    task automatic t_mid_reset();
        do_reset(1'b0);
        run_frames(3, 1'b1, '0, '0);
        #2;
        rst_ni = 1'b0;
        #1;
        check_idle("R8");
        @(negedge clk);
        #1;
        rst_ni = 1'b1;
        n = 0;
        run_frames(2, 1'b1, '0, '0);
    endtask

    initial begin
        t_reset_state();
        t_random_plain();
        t_random_inverted();
        t_bit_exact(1'b0, 32'hA5C3_0F81, 32'h1234_FEDC);
        t_bit_exact(1'b1, 32'h8000_0001, 32'h7FFF_FFFE);
        t_mid_reset();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule